// File: doc/BRIEF.md
# Serial Control Word Decoder for a Codec Interface

This block is the digital front end of a codec-style analog interface. A host shifts 16-bit words into it over a synchronous serial link, one bit per clock, while it holds a frame-active line high. Every word the host starts is a primary word. Its upper fourteen bits are a converter sample, and its two lowest bits are a communication code that decides whether an extra control word follows.

When a primary word carries the request code, the block waits a fixed number of clocks after the last bit and then sends a one-cycle secondary frame sync back to the host. The host answers with exactly one secondary word. The low bits of that word pick its target: the filter divider pair, the rate divider pair, or the control register. After the secondary word the link goes back to primary mode. The sample field of each primary word appears on a converter output with a one-cycle valid strobe. The stored divider and control fields drive the block's outputs.

Top module: `codec_ctl_decoder`

## Requirements
- R1: Bits are taken MSB first on each rising clock edge at which `frm_in` is high. Clocks with `frm_in` low neither shift a bit nor advance the bit count. A word is complete on the 16th accepted bit.
- R2: A primary word's bits 15..2 appear on `conv_data` one clock after its last bit, with `conv_valid` high for exactly one cycle, whatever its code.
- R3: A primary word with low bits 11 makes `fs_sec` rise on the 4th clock edge after the edge that took its last bit, for one cycle. Primary codes 00, 01 and 10 produce no `fs_sec`.
- R4: After `fs_sec`, exactly one word is treated as secondary. The word after it is primary again.
- R5: A secondary word with low bits 00 loads `filt_rx` from bits 6..2 and `filt_tx` from bits 13..9. Bits 8..7 and 15..14 are ignored, and the other registers keep their values.
- R6: A secondary word with low bits 01 loads `rate_rx` from bits 7..2 and `rate_tx` from bits 14..9. Bits 8 and 15 are ignored, and the other registers keep their values.
- R7: A secondary word with low bits 11 loads `ctrl_word` from bits 15..2. `bpf_on` equals word bit 2 (`ctrl_word[0]`) and `aux_sel` equals word bit 4 (`ctrl_word[2]`).
- R8: A secondary word with low bits 10 changes no register.
- R9: Bits presented between the end of a requesting primary word and the `fs_sec` pulse are discarded.
- R10: A synchronous active-high reset clears all registers, drops any pending request and drives no `fs_sec` or `conv_valid`.
- R11: A secondary word never strobes `conv_valid` and never updates `conv_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frm_in | input | 1 | Frame active from host, qualifies each bit |
| sdi | input | 1 | Serial data in, MSB first |
| fs_sec | output | 1 | One-cycle secondary frame sync to host |
| conv_data | output | 14 | Converter sample from the last primary word |
| conv_valid | output | 1 | One-cycle strobe for `conv_data` |
| filt_tx | output | 5 | Filter divider, transmit side |
| filt_rx | output | 5 | Filter divider, receive side |
| rate_tx | output | 6 | Rate divider, transmit side |
| rate_rx | output | 6 | Rate divider, receive side |
| ctrl_word | output | 14 | Control register image (word bits 15..2) |
| bpf_on | output | 1 | Input band-pass filter inserted |
| aux_sel | output | 1 | Auxiliary input selected |

## Verification
The bench first goes after the exact cycle of `fs_sec`. A counter that is off by one would make the pulse one clock early or late, and the bench samples the cycles on both sides. A frame driven during the countdown must be thrown away. A design that shifted those bits would misalign the secondary word and load wrong divider values. Frame-active gaps in the middle of a word check that idle clocks do not advance the bit count. Secondary words with each of the four codes, followed by a plain primary word, expose a decoder that routes fields to the wrong register, strobes the converter, or stays stuck in secondary mode.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;
  localparam int WORD_W   = 16;
  localparam int CODE_W   = 2;
  localparam int SAMPLE_W = WORD_W - CODE_W;
  localparam int FILT_W   = 5;
  localparam int RATE_W   = 6;

  // low-bit codes; primary: REQ asks for a secondary word
  typedef enum logic [CODE_W-1:0] {
    CODE_FILT = 2'b00,
    CODE_RATE = 2'b01,
    CODE_NOP  = 2'b10,
    CODE_CTRL = 2'b11
  } code_e;

  localparam logic [CODE_W-1:0] CODE_REQ = 2'b11;

  // field positions that the register decode depends on
  localparam int FILT_RX_LO = 2;
  localparam int FILT_TX_LO = 9;
  localparam int RATE_RX_LO = 2;
  localparam int RATE_TX_LO = 9;
endpackage

// File: rtl/codec_shift_rx.sv
module codec_shift_rx
  import codec_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_in,
  input  logic              sdi,
  input  logic              enable,
  output logic              done,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-2:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              take;

  assign take = frm_in && enable;
  assign done = take && (cnt_q == LAST);
  assign word = {sh_q, sdi};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (take) begin
      sh_q  <= {sh_q[WORD_W-3:0], sdi};
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/codec_sec_timer.sv
module codec_sec_timer
  import codec_ctl_pkg::*;
#(
  parameter int SEC_DELAY = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [CODE_W-1:0] code,
  output logic              pending,
  output logic              sec_mode,
  output logic              fs_sec
);
  localparam int DW = $clog2(SEC_DELAY + 1);
  localparam logic [DW-1:0] LOAD = DW'(SEC_DELAY - 1);

  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      pending  <= 1'b0;
      sec_mode <= 1'b0;
      fs_sec   <= 1'b0;
    end else begin
      fs_sec <= 1'b0;
      if (done) begin
        if (sec_mode) begin
          sec_mode <= 1'b0;
        end else if (code == CODE_REQ) begin
          pending <= 1'b1;
          cnt_q   <= LOAD;
        end
      end else if (pending) begin
        if (cnt_q == '0) begin
          pending  <= 1'b0;
          fs_sec   <= 1'b1;
          sec_mode <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assert_fs_single_R3: assert property (@(posedge clk) disable iff (rst)
    fs_sec |=> !fs_sec);
endmodule

// File: rtl/codec_reg_bank.sv
module codec_reg_bank
  import codec_ctl_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                done,
  input  logic                sec_mode,
  input  logic [WORD_W-1:0]   word,
  output logic [SAMPLE_W-1:0] conv_data,
  output logic                conv_valid,
  output logic [FILT_W-1:0]   filt_tx,
  output logic [FILT_W-1:0]   filt_rx,
  output logic [RATE_W-1:0]   rate_tx,
  output logic [RATE_W-1:0]   rate_rx,
  output logic [SAMPLE_W-1:0] ctrl_word
);
  code_e code;
  assign code = code_e'(word[CODE_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_data  <= '0;
      conv_valid <= 1'b0;
      filt_tx    <= '0;
      filt_rx    <= '0;
      rate_tx    <= '0;
      rate_rx    <= '0;
      ctrl_word  <= '0;
    end else begin
      conv_valid <= 1'b0;
      if (done && !sec_mode) begin
        conv_data  <= word[WORD_W-1:CODE_W];
        conv_valid <= 1'b1;
      end else if (done) begin
        case (code)
          CODE_FILT: begin
            filt_rx <= word[FILT_RX_LO +: FILT_W];
            filt_tx <= word[FILT_TX_LO +: FILT_W];
          end
          CODE_RATE: begin
            rate_rx <= word[RATE_RX_LO +: RATE_W];
            rate_tx <= word[RATE_TX_LO +: RATE_W];
          end
          CODE_CTRL: ctrl_word <= word[WORD_W-1:CODE_W];
          default: ;
        endcase
      end
    end
  end

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
    conv_valid |=> !conv_valid);

  assert_nop_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (done && sec_mode && word[1:0] == 2'b10) |=>
      $stable({filt_tx, filt_rx, rate_tx, rate_rx, ctrl_word}));
endmodule

// File: rtl/codec_ctl_decoder.sv
module codec_ctl_decoder
  import codec_ctl_pkg::*;
#(
  parameter int SEC_DELAY = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frm_in,
  input  logic                sdi,
  output logic                fs_sec,
  output logic [SAMPLE_W-1:0] conv_data,
  output logic                conv_valid,
  output logic [FILT_W-1:0]   filt_tx,
  output logic [FILT_W-1:0]   filt_rx,
  output logic [RATE_W-1:0]   rate_tx,
  output logic [RATE_W-1:0]   rate_rx,
  output logic [SAMPLE_W-1:0] ctrl_word,
  output logic                bpf_on,
  output logic                aux_sel
);
  logic              done;
  logic [WORD_W-1:0] word;
  logic              pending;
  logic              sec_mode;

  codec_shift_rx u_shift (
    .clk(clk), .rst(rst), .frm_in(frm_in), .sdi(sdi),
    .enable(!pending), .done(done), .word(word)
  );

  codec_sec_timer #(.SEC_DELAY(SEC_DELAY)) u_timer (
    .clk(clk), .rst(rst), .done(done), .code(word[CODE_W-1:0]),
    .pending(pending), .sec_mode(sec_mode), .fs_sec(fs_sec)
  );

  codec_reg_bank u_regs (
    .clk(clk), .rst(rst), .done(done), .sec_mode(sec_mode), .word(word),
    .conv_data(conv_data), .conv_valid(conv_valid),
    .filt_tx(filt_tx), .filt_rx(filt_rx),
    .rate_tx(rate_tx), .rate_rx(rate_rx), .ctrl_word(ctrl_word)
  );

  assign bpf_on  = ctrl_word[0];
  assign aux_sel = ctrl_word[2];

  assert_wait_discards_R9: assert property (@(posedge clk) disable iff (rst)
    pending |-> !done);

  assert_sec_no_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    (done && sec_mode) |=> !conv_valid);

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!fs_sec && !conv_valid && ctrl_word == '0 && filt_tx == '0
             && rate_tx == '0));
endmodule

// File: tb/test_codec_ctl_decoder.sv
`timescale 1ns/1ps
module test_codec_ctl_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_in = 1'b0;
  logic sdi = 1'b0;
  logic fs_sec, conv_valid, bpf_on, aux_sel;
  logic [13:0] conv_data, ctrl_word;
  logic [4:0] filt_tx, filt_rx;
  logic [5:0] rate_tx, rate_rx;

  int total = 0;
  int bad = 0;
  logic [4:0]  e_ftx = '0, e_frx = '0;
  logic [5:0]  e_rtx = '0, e_rrx = '0;
  logic [13:0] e_ctl = '0;

  always #2 clk = ~clk;

  codec_ctl_decoder i_codec_ctl_decoder (
    .clk(clk), .rst(rst), .frm_in(frm_in), .sdi(sdi), .fs_sec(fs_sec),
    .conv_data(conv_data), .conv_valid(conv_valid),
    .filt_tx(filt_tx), .filt_rx(filt_rx), .rate_tx(rate_tx), .rate_rx(rate_rx),
    .ctrl_word(ctrl_word), .bpf_on(bpf_on), .aux_sel(aux_sel)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_regs(string req);
    check(req, {27'd0, filt_tx}, {27'd0, e_ftx});
    check(req, {27'd0, filt_rx}, {27'd0, e_frx});
    check(req, {26'd0, rate_tx}, {26'd0, e_rtx});
    check(req, {26'd0, rate_rx}, {26'd0, e_rrx});
    check(req, {18'd0, ctrl_word}, {18'd0, e_ctl});
    check("R7 bpf", {31'd0, bpf_on}, {31'd0, e_ctl[0]});
    check("R7 aux", {31'd0, aux_sel}, {31'd0, e_ctl[2]});
  endtask

  // returns at the negedge after the edge that took the last bit
  task automatic send_word(logic [15:0] w, int gap_after);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); frm_in = 1'b1; sdi = w[15-i];
      if (i == gap_after) begin
        for (int g = 0; g < 3; g++) begin
          @(negedge clk); frm_in = 1'b0; sdi = ~sdi;
        end
        @(negedge clk); frm_in = 1'b1; sdi = w[15-i-1];
        i++;
      end
    end
    @(negedge clk); frm_in = 1'b0; sdi = 1'b0;
  endtask

  task automatic primary(logic [15:0] w, int gap_after);
    send_word(w, gap_after);
    check("R2 valid", {31'd0, conv_valid}, 32'd1);
    check("R2 R1 data", {18'd0, conv_data}, {18'd0, w[15:2]});
    check("R3 early", {31'd0, fs_sec}, 32'd0);
  endtask

  task automatic expect_sync(logic [1:0] code);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      check("R3 pre", {31'd0, fs_sec}, 32'd0);
      if (k == 1) check("R2 one-cycle", {31'd0, conv_valid}, 32'd0);
    end
    @(negedge clk);
    check("R3 sync", {31'd0, fs_sec}, {31'd0, code == 2'b11});
  endtask

  task automatic secondary(logic [15:0] w);
    logic [13:0] old_conv;
    old_conv = conv_data;
    send_word(w, 99);
    check("R11 strobe", {31'd0, conv_valid}, 32'd0);
    check("R11 data", {18'd0, conv_data}, {18'd0, old_conv});
    case (w[1:0])
      2'b00: begin e_frx = w[6:2]; e_ftx = w[13:9]; end
      2'b01: begin e_rrx = w[7:2]; e_rtx = w[14:9]; end
      2'b11: e_ctl = w[15:2];
      default: ;
    endcase
    case (w[1:0])
      2'b00: check_regs("R5 filt");
      2'b01: check_regs("R6 rate");
      2'b11: check_regs("R7 ctrl");
      default: check_regs("R8 nop");
    endcase
    check("R4 no resync", {31'd0, fs_sec}, 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 fs", {31'd0, fs_sec}, 32'd0);
    check("R10 valid", {31'd0, conv_valid}, 32'd0);
    check_regs("R10 regs");

    // directed: filter word with ignored bits set (R5)
    primary(16'hABCF, 99); expect_sync(2'b11);
    secondary(16'hC000 | 16'h0180 | 16'h162C);
    // directed: rate word with ignored bits set (R6)
    primary(16'h1237, 99); expect_sync(2'b11);
    secondary(16'h8000 | 16'h0100 | 16'h4891);
    // directed: control word selects band-pass and aux (R7)
    primary(16'h0003, 99); expect_sync(2'b11);
    secondary(16'h0017);
    // directed: nop code (R8)
    primary(16'hFFFF, 99); expect_sync(2'b11);
    secondary(16'h5A5E);
    // R4: following word is primary
    primary(16'h7770, 99); expect_sync(2'b00);
    // R1: frame gap in the middle of a word
    primary(16'hC3A5, 7); expect_sync(2'b01);

    // R9: host frame during countdown must be dropped
    send_word(16'h00FB, 99);
    check("R2 R9 valid", {31'd0, conv_valid}, 32'd1);
    @(negedge clk); frm_in = 1'b1; sdi = 1'b1;
    @(negedge clk); frm_in = 1'b1; sdi = 1'b0;
    @(negedge clk); frm_in = 1'b0;
    check("R9 pre", {31'd0, fs_sec}, 32'd0);
    @(negedge clk);
    check("R9 R3 sync", {31'd0, fs_sec}, 32'd1);
    secondary(16'h3E7D);

    // R3: reset during countdown drops the request (R10)
    send_word(16'h2223, 99);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    e_ftx = '0; e_frx = '0; e_rtx = '0; e_rrx = '0; e_ctl = '0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R10 no sync", {31'd0, fs_sec}, 32'd0);
    end
    check_regs("R10 cleared");

    // random traffic
    for (int n = 0; n < 250; n++) begin
      w = 16'($urandom);
      primary(w, (n % 5 == 0) ? int'($urandom_range(0, 13)) : 99);
      expect_sync(w[1:0]);
      if (w[1:0] == 2'b11) secondary(16'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule